// File: doc/BRIEF.md
# Fractional Half-Second Tick Generator

This block derives an exact one-second square wave and a free-running seconds count from a fast core clock whose frequency is not a whole multiple of the half-second rate. A prescaler slows the core clock into counter ticks. An internal counter of `CNT_W` bits then runs a fixed number of full wrap-arounds. After that it is preloaded so that only a short remainder of ticks is left. A small fractional accumulator lengthens that remainder by one tick whenever the sub-tick error it collects reaches a whole tick. With the default build (8 MHz core, divide by 1024, fifteen full wraps, remainder 66, a quarter tick carried per half-second), one half-second takes 3906¼ ticks on average, which is exactly 4,000,000 core clocks. A 400 kHz build uses divide by 256, three full wraps, a remainder of 13 and the same quarter step.

The sequencer has two states. In `PH_FULL` it counts full wrap-arounds. The transition FULL→TAIL is taken on the last full wrap: the counter is loaded with the span minus the remainder, and the fractional accumulator is updated at the same time. In `PH_TAIL` the counter runs out the remainder. The transition TAIL→FULL is taken on the next wrap, and it marks the end of a half-second. Each half-second end toggles the square-wave output. The seconds count increments only on the toggle that drives the output low, and a one-cycle strobe flags that increment. Software-free presetting of the count goes through a load port. A load wins over an increment in the same cycle.

Top module: `frac_sec_timer`

## Requirements
- R1: After synchronous reset, `seconds` equals `SEC_INIT` (default 2,524,608,000, i.e. twenty four-year cycles of seconds), and `sq_out` and `sec_inc` are 0.
- R2: A normal half-second lasts exactly `PRESCALE * (FULL_OVF * 2^CNT_W + REMAIN)` core clocks.
- R3: The fractional accumulator adds `FRAC_NUM` per half-second, modulo `FRAC_DEN`. A half-second in which the sum reaches `FRAC_DEN` lasts one tick (`PRESCALE` clocks) longer. With a quarter step, the fourth half-second after reset is the long one, and so is every fourth one after it.
- R4: `sq_out` toggles once at the end of each half-second. It is 1 during the second half-second of each second. After reset it first falls `2*R2 + 1` clocks after reset is released.
- R5: `seconds` increments by exactly one in the cycle when `sq_out` falls, and `sec_inc` is 1 for exactly that cycle.
- R6: When `load_en` is 1 at a clock edge, `seconds` takes `load_val` at that edge. If an increment is due at the same edge, the load wins, and `sec_inc` still pulses.
- R7: Any four consecutive seconds span exactly `4 * FRAC_DEN/2 * ...` that is, two full fractional cycles: `2 * (4*R2 + PRESCALE)` clocks with the quarter step (32,000,000 clocks at the default build).
- R8: Loading the seconds count does not disturb the timing of `sq_out` or `sec_inc`.
- R9: `seconds` wraps from all ones to zero on an increment.
- R10: A reset in mid-run restarts the prescaler, the sequencer and the fractional accumulator, so the long half-second again falls fourth after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous reset, active high |
| load_en | input | 1 | Preset the seconds count at this edge |
| load_val | input | SEC_W | Value to preset |
| sq_out | output | 1 | One-second square wave, low after reset |
| seconds | output | SEC_W | Running seconds count |
| sec_inc | output | 1 | One-cycle strobe when the count advances |

## Verification
The bench builds a shrunk instance (divide by 2, a 3-bit counter, two full wraps, remainder 3, a quarter step), so a half-second is 38 or 40 clocks. It measures the clocks between strobes, and the high time within each interval, over a run of seconds. The 78/76 alternation separates a correct fractional carry from a missing one or a misplaced one, and the four-second sums confirm that no tick is lost. Directed cases place a load exactly on an increment edge, load all ones to force the wrap, and reset in mid-run. The reset case tells a restarted accumulator from a stale one and checks the first-fall latency.

// File: rtl/rtc_tick_pkg.sv
package rtc_tick_pkg;
    typedef enum logic [0:0] {
        PH_FULL = 1'b0,
        PH_TAIL = 1'b1
    } phase_e;
endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
    parameter int unsigned DIV = 1024
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    localparam int unsigned PW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [PW-1:0] LAST = PW'(DIV - 1);

    logic [PW-1:0] pre_cnt;

    assign tick = (pre_cnt == LAST);

    always_ff @(posedge clk) begin
        if (rst)       pre_cnt <= '0;
        else if (tick) pre_cnt <= '0;
        else           pre_cnt <= pre_cnt + PW'(1);
    end

    generate
        if (DIV > 1) begin : g_spacing
            p_tick_gap_r2: assert property (@(posedge clk) disable iff (rst)
                tick |=> !tick)
                else $error("prescaler tick on two adjacent cycles");
        end
    endgenerate
endmodule

// File: rtl/rtc_tick_fsm.sv
module rtc_tick_fsm
    import rtc_tick_pkg::*;
#(
    parameter int unsigned CNT_W    = 8,
    parameter int unsigned FULL_OVF = 15,
    parameter int unsigned REMAIN   = 66,
    parameter int unsigned FRAC_NUM = 1,
    parameter int unsigned FRAC_DEN = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    output logic half_done
);
    localparam int unsigned FW = (FRAC_DEN > 1) ? $clog2(FRAC_DEN) : 1;
    localparam int unsigned OW = $clog2(FULL_OVF + 1);
    localparam logic [CNT_W:0]  SPAN    = (CNT_W + 1)'(1) << CNT_W;
    localparam logic [CNT_W:0]  REM_W   = (CNT_W + 1)'(REMAIN);
    localparam logic [FW:0]     DEN_W   = (FW + 1)'(FRAC_DEN);
    localparam logic [FW:0]     NUM_W   = (FW + 1)'(FRAC_NUM);
    localparam logic [OW-1:0]   LAST_OV = OW'(FULL_OVF - 1);

    phase_e          state, nxt_state;
    logic [CNT_W-1:0] tmr, nxt_tmr;
    logic [OW-1:0]   ovf_cnt, nxt_ovf;
    logic [FW-1:0]   acc, nxt_acc;
    logic            nxt_done;

    logic            wrap;
    logic [FW:0]     frac_sum;
    logic            frac_carry;
    logic [CNT_W:0]  tail_len;
    logic [CNT_W:0]  tail_diff;

    assign wrap       = tick && (tmr == '1);
    assign frac_sum   = {1'b0, acc} + NUM_W;
    assign frac_carry = (frac_sum >= DEN_W);
    assign tail_len   = REM_W + {{CNT_W{1'b0}}, frac_carry};
    assign tail_diff  = SPAN - tail_len;

    always_comb begin
        nxt_state = state;
        nxt_tmr   = tick ? tmr + CNT_W'(1) : tmr;
        nxt_ovf   = ovf_cnt;
        nxt_acc   = acc;
        nxt_done  = 1'b0;
        unique case (state)
            PH_FULL: begin
                if (wrap) begin
                    if (ovf_cnt == LAST_OV) begin
                        nxt_state = PH_TAIL;
                        nxt_tmr   = tail_diff[CNT_W-1:0];
                        nxt_acc   = frac_sum[FW-1:0];
                        nxt_ovf   = '0;
                    end else begin
                        nxt_ovf   = ovf_cnt + OW'(1);
                    end
                end
            end
            PH_TAIL: begin
                if (wrap) begin
                    nxt_state = PH_FULL;
                    nxt_done  = 1'b1;
                end
            end
            default: nxt_state = PH_FULL;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= PH_FULL;
            tmr       <= '0;
            ovf_cnt   <= '0;
            acc       <= '0;
            half_done <= 1'b0;
        end else begin
            state     <= nxt_state;
            tmr       <= nxt_tmr;
            ovf_cnt   <= nxt_ovf;
            acc       <= nxt_acc;
            half_done <= nxt_done;
        end
    end

    p_tail_idle_r2: assert property (@(posedge clk) disable iff (rst)
        (state == PH_TAIL) |-> (ovf_cnt == '0))
        else $error("wrap count nonzero while running the remainder");

    p_done_wrap_r3: assert property (@(posedge clk) disable iff (rst)
        half_done |-> (state == PH_FULL && tmr == '0))
        else $error("half-second end without a fresh full phase");
endmodule

// File: rtl/rtc_sec_count.sv
module rtc_sec_count #(
    parameter int unsigned       SEC_W    = 32,
    parameter logic [SEC_W-1:0]  SEC_INIT = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             half_done,
    input  logic             load_en,
    input  logic [SEC_W-1:0] load_val,
    output logic             sq_out,
    output logic [SEC_W-1:0] seconds,
    output logic             sec_inc
);
    logic going_low;

    assign going_low = half_done && sq_out;

    always_ff @(posedge clk) begin
        if (rst) begin
            sq_out  <= 1'b0;
            sec_inc <= 1'b0;
        end else begin
            sec_inc <= going_low;
            if (half_done) sq_out <= !sq_out;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)            seconds <= SEC_INIT;
        else if (load_en)   seconds <= load_val;
        else if (going_low) seconds <= seconds + SEC_W'(1);
    end

    p_inc_on_fall_r4: assert property (@(posedge clk) disable iff (rst)
        sec_inc |-> (!sq_out && $past(sq_out)))
        else $error("strobe without a falling square wave");

    p_step_one_r5: assert property (@(posedge clk) disable iff (rst)
        !load_en |=> (seconds == $past(seconds) ||
                      seconds == $past(seconds) + SEC_W'(1)))
        else $error("seconds moved by more than one");

    p_load_wins_r6: assert property (@(posedge clk) disable iff (rst)
        load_en |=> (seconds == $past(load_val)))
        else $error("load value not taken");
endmodule

// File: rtl/frac_sec_timer.sv
module frac_sec_timer #(
    parameter int unsigned      PRESCALE = 1024,
    parameter int unsigned      CNT_W    = 8,
    parameter int unsigned      FULL_OVF = 15,
    parameter int unsigned      REMAIN   = 66,
    parameter int unsigned      FRAC_NUM = 1,
    parameter int unsigned      FRAC_DEN = 4,
    parameter int unsigned      SEC_W    = 32,
    parameter logic [SEC_W-1:0] SEC_INIT = SEC_W'(64'd60 * 64'd60 * 64'd24 * 64'd1461 * 64'd20)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load_en,
    input  logic [SEC_W-1:0] load_val,
    output logic             sq_out,
    output logic [SEC_W-1:0] seconds,
    output logic             sec_inc
);
    localparam bit CFG_OK =
        (PRESCALE >= 1) && (CNT_W >= 1) && (CNT_W <= 16) &&
        (FULL_OVF >= 1) && (REMAIN >= 1) &&
        (REMAIN + 1 <= (1 << CNT_W)) &&
        (FRAC_DEN >= 2) && ((FRAC_DEN & (FRAC_DEN - 1)) == 0) &&
        (FRAC_NUM < FRAC_DEN);

    generate
        if (!CFG_OK) begin : g_bad_cfg
            $error("frac_sec_timer: illegal divider parameter combination");
        end
    endgenerate

    logic tick;
    logic half_done;

    rtc_prescaler #(
        .DIV (PRESCALE)
    ) u_pre (
        .clk  (clk),
        .rst  (rst),
        .tick (tick)
    );

    rtc_tick_fsm #(
        .CNT_W    (CNT_W),
        .FULL_OVF (FULL_OVF),
        .REMAIN   (REMAIN),
        .FRAC_NUM (FRAC_NUM),
        .FRAC_DEN (FRAC_DEN)
    ) u_seq (
        .clk       (clk),
        .rst       (rst),
        .tick      (tick),
        .half_done (half_done)
    );

    rtc_sec_count #(
        .SEC_W    (SEC_W),
        .SEC_INIT (SEC_INIT)
    ) u_cnt (
        .clk       (clk),
        .rst       (rst),
        .half_done (half_done),
        .load_en   (load_en),
        .load_val  (load_val),
        .sq_out    (sq_out),
        .seconds   (seconds),
        .sec_inc   (sec_inc)
    );
endmodule

// File: tb/frac_sec_timer_tb_top.sv
`timescale 1ns/1ps
module frac_sec_timer_tb_top;
    localparam int PRE  = 2;
    localparam int CW   = 3;
    localparam int NFUL = 2;
    localparam int REM  = 3;
    localparam int HS_S = PRE * (NFUL * (1 << CW) + REM);   // 38
    localparam int HS_L = HS_S + PRE;                       // 40
    localparam logic [31:0] INIT = 32'h967A7600;
    localparam int NV = 6;
    // {clocks between strobes, clocks with sq_out high}
    localparam int VEC [NV][2] = '{
        '{HS_S + HS_L, HS_L}, '{2 * HS_S, HS_S},
        '{HS_S + HS_L, HS_L}, '{2 * HS_S, HS_S},
        '{HS_S + HS_L, HS_L}, '{2 * HS_S, HS_S}};

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        load_en = 1'b0;
    logic [31:0] load_val = '0;
    logic        sq_out;
    logic [31:0] seconds;
    logic        sec_inc;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = !clk;

    frac_sec_timer #(
        .PRESCALE (PRE), .CNT_W (CW), .FULL_OVF (NFUL), .REMAIN (REM),
        .FRAC_NUM (1), .FRAC_DEN (4), .SEC_W (32)
    ) dut_i (
        .clk (clk), .rst (rst), .load_en (load_en), .load_val (load_val),
        .sq_out (sq_out), .seconds (seconds), .sec_inc (sec_inc)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", tag, act, act, exp, exp);
        end
    endtask

    task automatic wait_inc(output int len, output int high);
        len = 0;
        high = 0;
        do begin
            @(posedge clk);
            @(negedge clk);
            len++;
            if (sq_out) high++;
        end while (!sec_inc);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int len, high, prev;
        int lens [NV];
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 seconds after reset", seconds, INIT);
        chk("R1 sq_out after reset", {31'b0, sq_out}, 32'd0);
        chk("R1 sec_inc after reset", {31'b0, sec_inc}, 32'd0);
        rst = 1'b0;

        wait_inc(len, high);
        chk("R4 first fall latency", len, 2 * HS_S + 1);
        chk("R5 first increment", seconds, INIT + 1);
        prev = seconds;

        for (int i = 0; i < NV; i++) begin
            wait_inc(len, high);
            lens[i] = len;
            chk("R2 R3 second length", len, VEC[i][0]);
            chk("R4 high time", high, VEC[i][1]);
            chk("R5 step by one", seconds, prev + 1);
            prev = seconds;
        end
        chk("R7 four-second span a", lens[0] + lens[1] + lens[2] + lens[3], 2 * (3 * HS_S + HS_L));
        chk("R7 four-second span b", lens[2] + lens[3] + lens[4] + lens[5], 2 * (3 * HS_S + HS_L));

        // Next interval is long; place a load on the increment edge.
        repeat (HS_S + HS_L - 1) @(posedge clk);
        @(negedge clk);
        load_en = 1'b1;
        load_val = 32'h1234_5678;
        @(posedge clk);
        @(negedge clk);
        load_en = 1'b0;
        chk("R6 load wins over increment", seconds, 32'h1234_5678);
        chk("R6 strobe still pulses", {31'b0, sec_inc}, 32'd1);

        wait_inc(len, high);
        chk("R8 timing after load", len, 2 * HS_S);
        chk("R5 increment after load", seconds, 32'h1234_5679);

        load_en = 1'b1;
        load_val = 32'hFFFF_FFFF;
        @(posedge clk);
        @(negedge clk);
        load_en = 1'b0;
        chk("R6 plain load", seconds, 32'hFFFF_FFFF);
        wait_inc(len, high);
        chk("R8 timing across mid-second load", len + 1, HS_S + HS_L);
        chk("R9 wrap to zero", seconds, 32'd0);

        // Mid-run reset.
        repeat (10) @(posedge clk);
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        chk("R10 seconds after mid-run reset", seconds, INIT);
        chk("R10 sq_out after mid-run reset", {31'b0, sq_out}, 32'd0);
        rst = 1'b0;
        wait_inc(len, high);
        chk("R10 first fall latency after reset", len, 2 * HS_S + 1);
        wait_inc(len, high);
        chk("R10 R3 fraction restarted", len, HS_S + HS_L);

        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule